// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits that a synchronous burst memory uses during a four-beat access. A start value enters the block when one of two active-low address strobes is accepted at a rising clock edge. One strobe belongs to the processor and the other to a bus controller. After that, each sampled advance request moves the output to the next beat of the burst.

A mode input picks the beat order. The linear order counts upward modulo four. The interleaved order XORs the loaded start value with the beat number. The processor strobe takes priority over the controller strobe, and it only counts while the active-low chip enable is low. The block reports which strobe, if any, it accepted at the most recent edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the beat count and the start value clear, so `burst_addr` reads 00 and `strobe_src` reads 00 (none) after that edge.
- R2: A low `ads_proc_n` together with a low `ce1_n` at a rising edge loads `a_lo` as the start value and restarts the beat count. After that edge, `burst_addr` equals the loaded `a_lo` in either mode and `strobe_src` reads 01 (processor).
- R3: A low `ads_ctrl_n` at a rising edge, when the processor strobe is not accepted, loads `a_lo` the same way. `strobe_src` then reads 10 (controller).
- R4: When both strobes are low and `ce1_n` is low, only the processor strobe is accepted and `strobe_src` reads 01.
- R5: A low `ads_proc_n` while `ce1_n` is high is ignored. If `ads_ctrl_n` is also low, the controller load takes place. Otherwise the burst state does not change and `strobe_src` reads 00.
- R6: With no strobe accepted and `adv_n` low at a rising edge, the beat count steps by one, modulo four.
- R7: With `mode_ilv` low (linear order), `burst_addr` equals start plus beat count modulo four, so successive advances from 3 wrap to 0.
- R8: With `mode_ilv` high (interleaved order), `burst_addr` equals start XOR beat count. The output follows `mode_ilv` combinationally.
- R9: With no strobe accepted and `adv_n` high, start and beat count hold, and `strobe_src` reads 00.
- R10: An accepted strobe takes precedence over a simultaneous low `adv_n`: the block loads and does not step.
- R11: After four advances the beat count returns to zero, so the output returns to the start value in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_proc_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low; gates the processor strobe |
| adv_n | input | 1 | Advance request, active low |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| a_lo | input | LOW_W | Low address bits loaded as start value |
| burst_addr | output | LOW_W | Current burst address bits |
| strobe_src | output | 2 | Strobe accepted at last edge: 00 none, 01 processor, 10 controller |

## Verification
Loads, steps and holds all take effect at the same rising edge where the inputs are sampled. Their results are due on `burst_addr` and `strobe_src` one cycle after the stimulus is applied. The one exception is the order select: `mode_ilv` changes `burst_addr` in the same cycle, with no clock edge in between. The bench applies each vector on a falling edge and compares a quarter period after the next rising edge, before any input changes. The mode-flip test compares both values inside a single low clock phase.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Encoding of which strobe was accepted at the most recent edge.
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_PROC = 2'b01,
        SRC_CTRL = 2'b10
    } strobe_src_e;

    // Beat ordering selected by the mode input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Decision taken at one clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOAD = 2'b01,
        ACT_STEP = 2'b10
    } action_e;

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
    import burst_seq_pkg::*;
(
    input  logic        ads_proc_n,
    input  logic        ads_ctrl_n,
    input  logic        ce1_n,
    input  logic        adv_n,
    output strobe_src_e src,
    output action_e     act
);
    logic proc_ok;
    logic ctrl_ok;

    // The processor strobe counts only while the chip enable is low.
    // When it counts, it masks the controller strobe.
    assign proc_ok = ~ads_proc_n & ~ce1_n;
    assign ctrl_ok = ~ads_ctrl_n & ~proc_ok;

    always_comb begin
        if (proc_ok) begin
            src = SRC_PROC;
            act = ACT_LOAD;
        end else if (ctrl_ok) begin
            src = SRC_CTRL;
            act = ACT_LOAD;
        end else begin
            src = SRC_NONE;
            act = adv_n ? ACT_HOLD : ACT_STEP;
        end
    end
endmodule

// File: rtl/burst_order_unit.sv
module burst_order_unit
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] beat,
    input  order_e           order,
    output logic [LOW_W-1:0] addr
);
    logic [LOW_W-1:0] lin_addr;
    logic [LOW_W-1:0] ilv_addr;

    assign lin_addr = start + beat;

    // Interleaved order: each bit is flipped by the matching beat bit.
    for (genvar i = 0; i < LOW_W; i++) begin : g_ilv
        assign ilv_addr[i] = start[i] ^ beat[i];
    end

    assign addr = (order == ORD_INTERLEAVE) ? ilv_addr : lin_addr;

    // Both orders agree on the first beat of a burst.
    always_comb begin
        if (beat == '0) begin
            assert_first_beat_R2: assert (addr == start);
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             ce1_n,
    input  logic             adv_n,
    input  logic             mode_ilv,
    input  logic [LOW_W-1:0] a_lo,
    output logic [LOW_W-1:0] burst_addr,
    output logic [1:0]       strobe_src
);
    typedef struct packed {
        logic [LOW_W-1:0] start;
        logic [LOW_W-1:0] beat;
        strobe_src_e      src;
    } seq_state_t;

    seq_state_t  st_q;
    seq_state_t  st_d;
    strobe_src_e arb_src;
    action_e     arb_act;

    burst_strobe_arb u_arb (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .ce1_n      (ce1_n),
        .adv_n      (adv_n),
        .src        (arb_src),
        .act        (arb_act)
    );

    always_comb begin
        st_d     = st_q;
        st_d.src = arb_src;
        unique case (arb_act)
            ACT_LOAD: begin
                st_d.start = a_lo;
                st_d.beat  = '0;
            end
            ACT_STEP: st_d.beat = st_q.beat + 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{start: '0, beat: '0, src: SRC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    burst_order_unit #(.LOW_W(LOW_W)) u_order (
        .start (st_q.start),
        .beat  (st_q.beat),
        .order (order_e'(mode_ilv)),
        .addr  (burst_addr)
    );

    assign strobe_src = st_q.src;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (burst_addr == '0 && strobe_src == SRC_NONE));

    assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!ads_proc_n && !ce1_n) |=> (burst_addr == $past(a_lo)));

    assert_proc_priority_R4: assert property (@(posedge clk) disable iff (rst)
        (!ads_proc_n && !ce1_n) |=> (strobe_src == SRC_PROC));

    assert_ce_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && ads_ctrl_n) |=> (strobe_src == SRC_NONE));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ((ads_proc_n || ce1_n) && ads_ctrl_n && adv_n)
        |=> ($stable(st_q.start) && $stable(st_q.beat)));

    assert_step_linear_R6: assert property (@(posedge clk) disable iff (rst)
        ((ads_proc_n || ce1_n) && ads_ctrl_n && !adv_n && !mode_ilv)
        |=> (mode_ilv || burst_addr == LOW_W'($past(burst_addr) + 1'b1)));

    assert_src_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_src));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_W      = 2;
    localparam int NVEC       = 21;

    logic             clk = 1'b0;
    logic             rst;
    logic             ads_proc_n;
    logic             ads_ctrl_n;
    logic             ce1_n;
    logic             adv_n;
    logic             mode_ilv;
    logic [LOW_W-1:0] a_lo;
    logic [LOW_W-1:0] burst_addr;
    logic [1:0]       strobe_src;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.LOW_W(LOW_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .ce1_n      (ce1_n),
        .adv_n      (adv_n),
        .mode_ilv   (mode_ilv),
        .a_lo       (a_lo),
        .burst_addr (burst_addr),
        .strobe_src (strobe_src)
    );

    // Field order: rst, ads_proc_n, ads_ctrl_n, ce1_n, adv_n, mode_ilv,
    // a_lo[1:0], expected burst_addr[1:0], expected strobe_src[1:0].
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1_1_1_0_1_0_00_00_00, //  0 R1 reset
        12'b0_0_1_0_1_0_10_10_01, //  1 R2 processor load 2
        12'b0_1_1_0_0_0_00_11_00, //  2 R6 R7 step linear
        12'b0_1_1_0_0_0_00_00_00, //  3 R7 wrap 3->0
        12'b0_1_1_0_0_0_00_01_00, //  4 R7 R11
        12'b0_1_1_0_1_0_00_01_00, //  5 R9 hold
        12'b0_1_0_0_1_1_01_01_10, //  6 R3 controller load 1
        12'b0_1_1_0_0_1_00_00_00, //  7 R8 1^1
        12'b0_1_1_0_0_1_00_11_00, //  8 R8 1^2
        12'b0_1_1_0_0_1_00_10_00, //  9 R8 1^3
        12'b0_0_0_0_0_1_11_11_01, // 10 R4 R10 both strobes, advance
        12'b0_0_1_1_1_1_00_11_00, // 11 R5 gated processor ignored
        12'b0_0_0_1_1_0_10_10_10, // 12 R5 gated processor, controller wins
        12'b0_0_1_1_0_0_00_11_00, // 13 R5 R6 gated strobe, step
        12'b0_1_0_0_0_0_00_00_10, // 14 R10 controller beats advance
        12'b0_0_1_0_1_1_10_10_01, // 15 R2 load 2 interleaved
        12'b0_1_1_0_0_1_00_11_00, // 16 R8
        12'b0_1_1_0_0_1_00_00_00, // 17 R8
        12'b0_1_1_0_0_1_00_01_00, // 18 R8
        12'b0_1_1_0_0_1_00_10_00, // 19 R11 back to start
        12'b1_0_0_0_0_1_11_00_00  // 20 R1 reset overrides everything
    };

    task automatic check(input string tag, input logic [1:0] got_a,
                         input logic [1:0] exp_a, input logic [1:0] got_s,
                         input logic [1:0] exp_s);
        n_cmp++;
        if (got_a !== exp_a || got_s !== exp_s) begin
            n_bad++;
            $display("FAIL %s: addr=%b src=%b expected addr=%b src=%b",
                     tag, got_a, got_s, exp_a, exp_s);
        end
    endtask

    task automatic drive(input logic [11:0] v);
        {rst, ads_proc_n, ads_ctrl_n, ce1_n, adv_n, mode_ilv, a_lo} = v[11:4];
    endtask

    task automatic cycle_and_sample();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        drive(12'b1_1_1_0_1_0_00_00_00);
        cycle_and_sample();
        @(negedge clk);
        cycle_and_sample();
        check("R1 reset state", burst_addr, 2'b00, strobe_src, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            cycle_and_sample();
            check($sformatf("vector %0d", i), burst_addr, VEC[i][3:2],
                  strobe_src, VEC[i][1:0]);
        end

        // R8: the order follows mode_ilv without a clock edge.
        // Start 3, one beat: linear gives 0, interleaved gives 2.
        @(negedge clk);
        drive(12'b0_0_1_0_1_0_11_00_00);
        cycle_and_sample();
        check("R2 load 3", burst_addr, 2'b11, strobe_src, 2'b01);
        @(negedge clk);
        drive(12'b0_1_1_0_0_0_00_00_00);
        cycle_and_sample();
        check("R7 linear 3+1", burst_addr, 2'b00, strobe_src, 2'b00);
        @(negedge clk);
        drive(12'b0_1_1_0_1_1_00_00_00);
        #1;
        check("R8 mode flip to interleaved", burst_addr, 2'b10, strobe_src, 2'b00);
        mode_ilv = 1'b0;
        #1;
        check("R8 mode flip back to linear", burst_addr, 2'b00, strobe_src, 2'b00);

        // R9: a long hold with strobes inactive leaves the value unchanged.
        for (int k = 0; k < 3; k++) begin
            cycle_and_sample();
            check("R9 hold", burst_addr, 2'b00, strobe_src, 2'b00);
        end

        // R1: reset in the middle of a burst clears the beat count.
        @(negedge clk);
        rst = 1'b1;
        cycle_and_sample();
        check("R1 mid-burst reset", burst_addr, 2'b00, strobe_src, 2'b00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule